// File: doc/BRIEF.md
# SPI Dual-Mode Data Buffer Controller

This block connects a processor's register interface to an SPI shift register. It manages transmit and receive word storage and reports whether each direction is full. The processor sees a single data location. A write to that location queues a word for transmission. A read returns the oldest received word. The two directions use separate storage, so a write never changes what a read returns. On the other side, the shifter pulls the next transmit word with a one-cycle load request while transmit data is available. It hands over each received word with a one-cycle strobe.

A mode input selects the depth of each direction. In single mode each direction holds one word. In queued mode each direction is a FIFO of `DEPTH` words. A full flag rises only when the last free entry is taken, and it falls as soon as one entry frees up. A small state machine follows the enable and mode inputs. Its states are `ST_OFF` (disabled), `ST_STD` (single) and `ST_ENH` (queued). Whenever the requested state differs from the current one, the machine takes a flush transition: both stores are emptied and the machine moves to the requested state on the same edge. The transitions are OFF→STD, OFF→ENH, STD↔ENH, STD→OFF and ENH→OFF. A write that is refused and a received word that is lost each set a sticky error flag. Each flag is cleared with its own one-cycle clear pulse.

Top module: `spi_bufctl`

## Requirements
- R1: In single mode, a processor write sets `tx_full` and `tx_avail` after the next clock edge and presents the word on `tx_word`. A shifter load then clears both flags.
- R2: In queued mode, `tx_full` stays 0 after `DEPTH-1` writes and is 1 after write number `DEPTH`. One load clears it. Words leave on `tx_word` in the order they were written.
- R3: In single mode, a receive strobe sets `rx_full` and shows the word on `cpu_rdata`. A processor read clears `rx_full`.
- R4: In queued mode, `rx_full` is 1 only after `DEPTH` unread words have been received. One read clears it. Reads return the words in arrival order.
- R5: A processor write does not change `cpu_rdata` or `rx_full`. A receive strobe does not change `tx_word` or `tx_avail`.
- R6: A write while transmit storage is full, with no load in the same cycle, is dropped and sets the sticky `wcol` flag. A pulse on `clr_wcol` clears it.
- R7: A receive strobe while receive storage is full, with no read in the same cycle, drops the word and sets the sticky `rovf` flag. A pulse on `clr_rovf` clears it.
- R8: A change of `enh_mode` or a drop of `en` empties both stores. After the next edge, `tx_full`, `rx_full` and `tx_avail` are 0.
- R9: A write and a load in the same cycle both take effect, as do a read and a receive strobe in the same cycle. With a full single-mode store, the new word replaces the old, the full flag stays 1 and no error flag is set.
- R10: While `en` is 0, writes and receive strobes are ignored: no flag is set and nothing is queued once the block is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable |
| enh_mode | input | 1 | 1 selects queued mode, 0 selects single mode |
| cpu_wr | input | 1 | Processor write strobe to the data location |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rd | input | 1 | Processor read strobe (pops one receive word) |
| cpu_rdata | output | DATA_W | Oldest received word |
| clr_wcol | input | 1 | Clears the write-collision flag |
| clr_rovf | input | 1 | Clears the receive-overflow flag |
| tx_full | output | 1 | Transmit storage full |
| rx_full | output | 1 | Receive storage full |
| wcol | output | 1 | Sticky write-collision flag |
| rovf | output | 1 | Sticky receive-overflow flag |
| tx_avail | output | 1 | Transmit word available for the shifter |
| sh_load | input | 1 | Shifter takes `tx_word` this cycle |
| tx_word | output | DATA_W | Next word to transmit |
| sh_rx_vld | input | 1 | Shifter delivers a received word this cycle |
| sh_rx_word | input | DATA_W | Received word |

## Verification
Two pairs of events can land on the same edge. A processor write can coincide with a shifter load, and a processor read can coincide with a receive strobe. The bench first fills single-mode storage. It then drives the competing pair in one cycle and checks three things: the full flag is still set, the output word is the new one, and no error flag has risen. This shows that both operations took effect and that neither counted as a collision. It also checks the error case, where the same full condition without the competing pop must drop the word and raise the sticky flag.

// File: rtl/spi_bufctl_pkg.sv
package spi_bufctl_pkg;
    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_STD = 2'd1,
        ST_ENH = 2'd2
    } buf_mode_e;
endpackage

// File: rtl/spi_buf_fifo.sv
// Circular word store; usable capacity chosen at run time (1 or DEPTH).
// DEPTH must be a power of two so pointers wrap naturally.
module spi_buf_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          not_empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok;

    assign not_empty = (count != '0);
    assign full      = (count == cap);
    assign pop_ok    = pop && not_empty;
    assign push_ok   = push && (!full || pop_ok);
    assign head      = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spi_buf_ctrl.sv
// Mode state machine: tracks enable/mode, flushes on every state change.
module spi_buf_ctrl
    import spi_bufctl_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          enh_mode,
    output logic          flush,
    output logic          active,
    output logic [CW-1:0] cap
);
    buf_mode_e state_q, target;

    assign target = !en ? ST_OFF : (enh_mode ? ST_ENH : ST_STD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= target;
    end

    always_comb begin
        flush  = (target != state_q);
        active = 1'b0;
        cap    = CW'(1);
        unique case (state_q)
            ST_OFF: begin
                active = 1'b0;
                cap    = CW'(1);
            end
            ST_STD: begin
                active = !flush;
                cap    = CW'(1);
            end
            ST_ENH: begin
                active = !flush;
                cap    = CW'(DEPTH);
            end
            default: begin
                active = 1'b0;
                cap    = CW'(1);
            end
        endcase
    end
endmodule

// File: rtl/spi_bufctl.sv
module spi_bufctl #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              enh_mode,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              clr_wcol,
    input  logic              clr_rovf,
    output logic              tx_full,
    output logic              rx_full,
    output logic              wcol,
    output logic              rovf,
    output logic              tx_avail,
    input  logic              sh_load,
    output logic [DATA_W-1:0] tx_word,
    input  logic              sh_rx_vld,
    input  logic [DATA_W-1:0] sh_rx_word
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic          flush, active;
    logic [CW-1:0] cap;
    logic          tx_push, tx_pop, rx_push, rx_pop, rx_avail;

    spi_buf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .enh_mode(enh_mode),
        .flush(flush), .active(active), .cap(cap)
    );

    assign tx_push = active && cpu_wr;
    assign tx_pop  = active && sh_load;
    assign rx_push = active && sh_rx_vld;
    assign rx_pop  = active && cpu_rd;

    spi_buf_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
        .push(tx_push), .push_data(cpu_wdata), .pop(tx_pop),
        .head(tx_word), .not_empty(tx_avail), .full(tx_full)
    );

    spi_buf_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
        .push(rx_push), .push_data(sh_rx_word), .pop(rx_pop),
        .head(cpu_rdata), .not_empty(rx_avail), .full(rx_full)
    );

    // Sticky error flags; a new error wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcol <= 1'b0;
            rovf <= 1'b0;
        end else begin
            if (tx_push && tx_full && !(tx_pop && tx_avail)) wcol <= 1'b1;
            else if (clr_wcol)                               wcol <= 1'b0;
            if (rx_push && rx_full && !(rx_pop && rx_avail)) rovf <= 1'b1;
            else if (clr_rovf)                               rovf <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_bufctl_chk.sv
module spi_bufctl_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic enh_mode,
    input logic cpu_wr,
    input logic cpu_rd,
    input logic sh_load,
    input logic sh_rx_vld,
    input logic clr_wcol,
    input logic clr_rovf,
    input logic tx_full,
    input logic rx_full,
    input logic tx_avail,
    input logic wcol,
    input logic rovf,
    input logic active,
    input logic flush
);
    // R1
    p_std_wr_sets_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        active && !enh_mode && cpu_wr |=> tx_full);
    // R1
    p_std_load_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        active && !enh_mode && sh_load && tx_avail && !cpu_wr |=> !tx_full);
    // R3
    p_std_rd_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active && !enh_mode && cpu_rd && rx_full && !sh_rx_vld |=> !rx_full);
    // R6
    p_wcol_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active && cpu_wr && tx_full && !sh_load |=> wcol);
    // R6
    p_wcol_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wcol && !clr_wcol |=> wcol);
    // R7
    p_rovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rovf && !clr_rovf |=> rovf);
    // R8
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !tx_full && !rx_full && !tx_avail);
    // R10
    p_off_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tx_avail && !rx_full);
endmodule

bind spi_bufctl spi_bufctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .enh_mode(enh_mode),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .sh_load(sh_load), .sh_rx_vld(sh_rx_vld),
    .clr_wcol(clr_wcol), .clr_rovf(clr_rovf), .tx_full(tx_full), .rx_full(rx_full),
    .tx_avail(tx_avail), .wcol(wcol), .rovf(rovf), .active(active), .flush(flush)
);

// File: tb/test_spi_bufctl.sv
module test_spi_bufctl;
    localparam int W = 16;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, enh_mode = 1'b0;
    logic cpu_wr = 1'b0, cpu_rd = 1'b0, clr_wcol = 1'b0, clr_rovf = 1'b0;
    logic sh_load = 1'b0, sh_rx_vld = 1'b0;
    logic [W-1:0] cpu_wdata = '0, sh_rx_word = '0;
    logic [W-1:0] cpu_rdata, tx_word;
    logic tx_full, rx_full, wcol, rovf, tx_avail;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;   // 250 MHz

    spi_bufctl #(.DATA_W(W), .DEPTH(DEPTH)) i_spi_bufctl (
        .clk(clk), .rst_n(rst_n), .en(en), .enh_mode(enh_mode),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .clr_wcol(clr_wcol), .clr_rovf(clr_rovf), .tx_full(tx_full), .rx_full(rx_full),
        .wcol(wcol), .rovf(rovf), .tx_avail(tx_avail), .sh_load(sh_load),
        .tx_word(tx_word), .sh_rx_vld(sh_rx_vld), .sh_rx_word(sh_rx_word)
    );

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic [W-1:0] d);
        cpu_wr = 1'b1; cpu_wdata = d; cyc(); cpu_wr = 1'b0;
    endtask
    task automatic ld();
        sh_load = 1'b1; cyc(); sh_load = 1'b0;
    endtask
    task automatic rxin(input logic [W-1:0] d);
        sh_rx_vld = 1'b1; sh_rx_word = d; cyc(); sh_rx_vld = 1'b0;
    endtask
    task automatic rd();
        cpu_rd = 1'b1; cyc(); cpu_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk({15'd0, tx_full}, 16'd0, "R1 reset tx_full");
        chk({15'd0, rx_full}, 16'd0, "R3 reset rx_full");
        chk({15'd0, tx_avail}, 16'd0, "R1 reset tx_avail");
        chk({14'd0, wcol, rovf}, 16'd0, "R6 R7 reset error flags");
    endtask

    task automatic t_std_tx();
        wr(16'hA5A5);
        chk({15'd0, tx_full}, 16'd1, "R1 tx_full after write");
        chk(tx_word, 16'hA5A5, "R1 tx_word");
        ld();
        chk({15'd0, tx_full}, 16'd0, "R1 tx_full after load");
        chk({15'd0, tx_avail}, 16'd0, "R1 tx_avail after load");
    endtask

    task automatic t_std_rx();
        rxin(16'h1234);
        chk({15'd0, rx_full}, 16'd1, "R3 rx_full after strobe");
        chk(cpu_rdata, 16'h1234, "R3 cpu_rdata");
        chk({15'd0, tx_avail}, 16'd0, "R5 strobe leaves tx empty");
        wr(16'hBEEF);
        chk(cpu_rdata, 16'h1234, "R5 write leaves rdata");
        chk({15'd0, rx_full}, 16'd1, "R5 write leaves rx_full");
        chk(tx_word, 16'hBEEF, "R5 tx_word separate");
        rd();
        chk({15'd0, rx_full}, 16'd0, "R3 rx_full after read");
        ld();
    endtask

    task automatic t_wcol();
        wr(16'h0001);
        wr(16'h0002);
        chk({15'd0, wcol}, 16'd1, "R6 wcol set");
        chk(tx_word, 16'h0001, "R6 dropped write");
        cyc();
        chk({15'd0, wcol}, 16'd1, "R6 wcol sticky");
        clr_wcol = 1'b1; cyc(); clr_wcol = 1'b0;
        chk({15'd0, wcol}, 16'd0, "R6 wcol cleared");
        ld();
    endtask

    task automatic t_rovf();
        rxin(16'h0007);
        rxin(16'h0008);
        chk({15'd0, rovf}, 16'd1, "R7 rovf set");
        chk(cpu_rdata, 16'h0007, "R7 word dropped");
        clr_rovf = 1'b1; cyc(); clr_rovf = 1'b0;
        chk({15'd0, rovf}, 16'd0, "R7 rovf cleared");
        rd();
    endtask

    task automatic t_concurrent();
        wr(16'h0010);
        cpu_wr = 1'b1; cpu_wdata = 16'h0011; sh_load = 1'b1;
        cyc();
        cpu_wr = 1'b0; sh_load = 1'b0;
        chk({15'd0, tx_full}, 16'd1, "R9 tx_full after write+load");
        chk(tx_word, 16'h0011, "R9 new tx word");
        chk({15'd0, wcol}, 16'd0, "R9 no wcol");
        ld();
        rxin(16'h0020);
        sh_rx_vld = 1'b1; sh_rx_word = 16'h0021; cpu_rd = 1'b1;
        cyc();
        sh_rx_vld = 1'b0; cpu_rd = 1'b0;
        chk({15'd0, rx_full}, 16'd1, "R9 rx_full after read+strobe");
        chk(cpu_rdata, 16'h0021, "R9 new rx word");
        chk({15'd0, rovf}, 16'd0, "R9 no rovf");
        rd();
    endtask

    task automatic t_enh();
        enh_mode = 1'b1; cyc(); cyc();
        for (int i = 0; i < DEPTH - 1; i++) wr(16'h0100 + 16'(i));
        chk({15'd0, tx_full}, 16'd0, "R2 not full at DEPTH-1");
        wr(16'h0100 + 16'(DEPTH - 1));
        chk({15'd0, tx_full}, 16'd1, "R2 full at DEPTH");
        chk(tx_word, 16'h0100, "R2 head order");
        ld();
        chk({15'd0, tx_full}, 16'd0, "R2 cleared after one load");
        for (int i = 1; i < DEPTH; i++) begin
            chk(tx_word, 16'h0100 + 16'(i), "R2 fifo order");
            ld();
        end
        for (int i = 0; i < DEPTH - 1; i++) rxin(16'h0200 + 16'(i));
        chk({15'd0, rx_full}, 16'd0, "R4 not full at DEPTH-1");
        rxin(16'h0200 + 16'(DEPTH - 1));
        chk({15'd0, rx_full}, 16'd1, "R4 full at DEPTH");
        rd();
        chk({15'd0, rx_full}, 16'd0, "R4 cleared after one read");
        for (int i = 1; i < DEPTH; i++) begin
            chk(cpu_rdata, 16'h0200 + 16'(i), "R4 fifo order");
            rd();
        end
    endtask

    task automatic t_flush();
        wr(16'h0301); wr(16'h0302);
        rxin(16'h0401);
        enh_mode = 1'b0; cyc();
        chk({15'd0, tx_avail}, 16'd0, "R8 mode change empties tx");
        chk({15'd0, rx_full}, 16'd0, "R8 mode change rx_full");
        cyc();
        wr(16'h0303);
        rxin(16'h0402);
        en = 1'b0; cyc();
        chk({15'd0, tx_full}, 16'd0, "R8 disable clears tx_full");
        chk({15'd0, rx_full}, 16'd0, "R8 disable clears rx_full");
    endtask

    task automatic t_off();
        wr(16'h0555);
        rxin(16'h0666);
        chk({15'd0, tx_avail}, 16'd0, "R10 write ignored");
        chk({15'd0, rx_full}, 16'd0, "R10 strobe ignored");
        chk({14'd0, wcol, rovf}, 16'd0, "R10 no error flags");
        en = 1'b1; cyc(); cyc();
        chk({15'd0, tx_avail}, 16'd0, "R10 nothing queued after enable");
        chk({15'd0, rx_full}, 16'd0, "R10 rx empty after enable");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        en = 1'b1;
        cyc(); cyc();
        t_reset();
        t_std_tx();
        t_std_rx();
        t_wcol();
        t_rovf();
        t_concurrent();
        t_enh();
        t_flush();
        t_off();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule